// File: doc/BRIEF.md
# Cache Miss Type Classifier

This block observes the stream of block addresses that a direct-mapped cache receives. With each address it gets the cache's own verdict, hit or miss. It sorts every miss into one of three causes. A miss is *compulsory* when the block has never been referenced since reset, which is a miss that even an unbounded cache would take. It is *capacity* when a fully-associative cache with the same line count would also have missed, because too many other blocks were used before this one came back. It is *conflict* when that fully-associative cache would have held the block, so the miss comes only from the fixed address-to-set mapping of the direct-mapped cache. The block keeps two internal models to make this decision. The first is a one-bit-per-block record of every block ever touched. The second is a shadow fully-associative store with least-recently-used replacement.

Accesses arrive on a valid/ready stream. `in_ready` is held high: the block takes one access every cycle and never applies back-pressure. Every accepted access produces one result on the output side exactly one cycle later, flagged by `out_valid`. That output has no ready signal, so the consumer must take each result in the cycle it appears. Three saturating counters keep a running total of each miss class.

Top module: `miss_classifier`

## Requirements
- R1: `in_ready` is high whenever reset is released, and each cycle with `in_valid` high is accepted. `out_valid` is high in the cycle after an accepted access, and the class for that access is on `out_class` in that same cycle.
- R2: An access reported with `in_hit` = 1 gives class code 2'b00 (hit) and leaves all three counters unchanged.
- R3: A miss on a block that has not been accessed since reset gives class code 2'b01 (compulsory).
- R4: A miss on a block accessed earlier but absent from the shadow fully-associative store gives class code 2'b10 (capacity).
- R5: A miss on a block accessed earlier and still present in the shadow store gives class code 2'b11 (conflict).
- R6: The shadow store holds `LINES` blocks. Every accepted access, hit or miss, makes its block the most recently used entry. When a new block enters a full store, the least recently used entry is evicted.
- R7: For each accepted miss, the counter for its class (`cnt_compulsory`, `cnt_capacity`, `cnt_conflict`) goes up by one. At 2^CNT_W-1 it holds and does not wrap.
- R8: Reset (`rst_n` low) clears the seen-block record, the shadow store and all counters, and drives `out_valid` low. Blocks touched before the reset count as never seen afterwards.
- R9: A cycle with `in_valid` low changes no state. `out_valid` is low in the following cycle and the counters hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An access is presented this cycle |
| in_ready | output | 1 | Access accepted (held high) |
| in_blk | input | BLK_W | Block address of the access |
| in_hit | input | 1 | Outcome in the observed cache: 1 hit, 0 miss |
| out_valid | output | 1 | Class result valid |
| out_class | output | 2 | 00 hit, 01 compulsory, 10 capacity, 11 conflict |
| cnt_compulsory | output | CNT_W | Saturating count of compulsory misses |
| cnt_capacity | output | CNT_W | Saturating count of capacity misses |
| cnt_conflict | output | CNT_W | Saturating count of conflict misses |

## Verification
The bound checker verifies on every cycle the parts of the behaviour that hold at the port level: results follow accepted accesses one cycle later, idle cycles produce no result, a reported hit always gives code 00 and a miss never does, each counter moves only in single steps that match the reported class, and a saturated counter holds. Separating capacity misses from conflict misses depends on the recency history of the shadow store, so only the bench scenarios can show it. These are a directed sequence in which a hit refresh changes which block is evicted, and a long stream scored against an independent reference model. The saturation value, clearing at reset, and compulsory misses that reappear after a mid-run reset are also shown by the scenarios.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  // Class codes reported per access.
  typedef enum logic [1:0] {
    CLS_HIT      = 2'b00,
    CLS_FIRST    = 2'b01,
    CLS_CAPACITY = 2'b10,
    CLS_CONFLICT = 2'b11
  } miss_cls_e;
endpackage

// File: rtl/mcc_seen_map.sv
// One bit per block address: set the first time the block is accessed.
module mcc_seen_map #(
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] look_blk,
  input  logic             set_en,
  output logic             seen
);
  localparam int DEPTH = 1 << BLK_W;

  logic [DEPTH-1:0] seen_q;

  assign seen = seen_q[look_blk];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (set_en) begin
      seen_q[look_blk] <= 1'b1;
    end
  end
endmodule

// File: rtl/mcc_lru_shadow.sv
// Fully-associative shadow tag store with true LRU ordering.
// Each way holds an age; the ages always form a permutation of 0..LINES-1,
// age 0 is the most recently used way and age LINES-1 is the eviction victim.
module mcc_lru_shadow #(
  parameter int BLK_W = 8,
  parameter int LINES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic [BLK_W-1:0] acc_blk,
  output logic             present
);
  localparam int AGE_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [AGE_W-1:0] OLDEST = AGE_W'(LINES - 1);

  logic [BLK_W-1:0] tag_q [LINES];
  logic [AGE_W-1:0] age_q [LINES];
  logic [LINES-1:0] vld_q;

  logic [LINES-1:0] hit_vec;
  logic [LINES-1:0] victim_vec;
  logic [LINES-1:0] pick_vec;
  logic [AGE_W-1:0] pick_age;

  for (genvar w = 0; w < LINES; w++) begin : g_cmp
    assign hit_vec[w]    = vld_q[w] && (tag_q[w] == acc_blk);
    assign victim_vec[w] = (age_q[w] == OLDEST);
  end

  assign present  = |hit_vec;
  assign pick_vec = present ? hit_vec : victim_vec;

  always_comb begin
    pick_age = '0;
    for (int w = 0; w < LINES; w++) begin
      if (pick_vec[w]) begin
        pick_age = pick_age | age_q[w];
      end
    end
  end

  for (genvar w = 0; w < LINES; w++) begin : g_way
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[w] <= '0;
        vld_q[w] <= 1'b0;
        age_q[w] <= AGE_W'(w);
      end else if (acc_en) begin
        if (pick_vec[w]) begin
          tag_q[w] <= acc_blk;
          vld_q[w] <= 1'b1;
          age_q[w] <= '0;
        end else if (age_q[w] < pick_age) begin
          age_q[w] <= age_q[w] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mcc_sat_counter.sv
// Counter that stops at its all-ones value.
module mcc_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (inc && (count != TOP)) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/miss_classifier.sv
module miss_classifier #(
  parameter int BLK_W = 8,
  parameter int LINES = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BLK_W-1:0] in_blk,
  input  logic             in_hit,
  output logic             out_valid,
  output logic [1:0]       out_class,
  output logic [CNT_W-1:0] cnt_compulsory,
  output logic [CNT_W-1:0] cnt_capacity,
  output logic [CNT_W-1:0] cnt_conflict
);
  import mcc_pkg::*;

  localparam int NCLS = 3;

  logic      accept;
  logic      blk_seen;
  logic      blk_in_shadow;
  miss_cls_e cls_next;
  logic [NCLS-1:0] inc_vec;
  logic [CNT_W-1:0] cnt_arr [NCLS];

  assign in_ready = 1'b1;
  assign accept   = in_valid && in_ready;

  mcc_seen_map #(.BLK_W(BLK_W)) u_seen (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_blk (in_blk),
    .set_en   (accept),
    .seen     (blk_seen)
  );

  mcc_lru_shadow #(.BLK_W(BLK_W), .LINES(LINES)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_en  (accept),
    .acc_blk (in_blk),
    .present (blk_in_shadow)
  );

  always_comb begin
    if (in_hit)              cls_next = CLS_HIT;
    else if (!blk_seen)      cls_next = CLS_FIRST;
    else if (!blk_in_shadow) cls_next = CLS_CAPACITY;
    else                     cls_next = CLS_CONFLICT;
  end

  // Counter k counts class code k+1.
  for (genvar k = 0; k < NCLS; k++) begin : g_cnt
    assign inc_vec[k] = accept && (cls_next == miss_cls_e'(k + 1));
    mcc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc_vec[k]),
      .count (cnt_arr[k])
    );
  end

  assign cnt_compulsory = cnt_arr[0];
  assign cnt_capacity   = cnt_arr[1];
  assign cnt_conflict   = cnt_arr[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_class <= 2'b00;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_class <= cls_next;
      end
    end
  end
endmodule

// File: rtl/miss_classifier_chk.sv
module miss_classifier_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_hit,
  input logic             out_valid,
  input logic [1:0]       out_class,
  input logic [CNT_W-1:0] cnt_compulsory,
  input logic [CNT_W-1:0] cnt_capacity,
  input logic [CNT_W-1:0] cnt_conflict
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r9_idle_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r2_hit_code: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_hit) |=> (out_class == 2'b00));

  a_r3_miss_not_hit_code: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_hit) |=> (out_class != 2'b00));

  a_r7_first_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_compulsory != $past(cnt_compulsory)) |->
      (cnt_compulsory == $past(cnt_compulsory) + ONE && out_valid && out_class == 2'b01));

  a_r7_capacity_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_capacity != $past(cnt_capacity)) |->
      (cnt_capacity == $past(cnt_capacity) + ONE && out_valid && out_class == 2'b10));

  a_r7_conflict_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_conflict != $past(cnt_conflict)) |->
      (cnt_conflict == $past(cnt_conflict) + ONE && out_valid && out_class == 2'b11));

  a_r7_first_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_compulsory) == TOP) |-> (cnt_compulsory == TOP));

  a_r7_capacity_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_capacity) == TOP) |-> (cnt_capacity == TOP));

  a_r7_conflict_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_conflict) == TOP) |-> (cnt_conflict == TOP));
endmodule

bind miss_classifier miss_classifier_chk #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .in_hit         (in_hit),
  .out_valid      (out_valid),
  .out_class      (out_class),
  .cnt_compulsory (cnt_compulsory),
  .cnt_capacity   (cnt_capacity),
  .cnt_conflict   (cnt_conflict)
);

// File: tb/tb_miss_classifier.sv
`timescale 1ns/1ps
module tb_miss_classifier;
  localparam int BLK_W = 8;
  localparam int LINES = 4;
  localparam int CNT_W = 4;
  localparam int TOP   = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [BLK_W-1:0] in_blk = '0;
  logic             in_hit = 1'b0;
  logic             out_valid;
  logic [1:0]       out_class;
  logic [CNT_W-1:0] cnt_compulsory, cnt_capacity, cnt_conflict;

  int checks = 0;
  int errors = 0;

  logic [1:0] exp_q[$];
  string      req_q[$];

  // Reference state for the random phase.
  bit seen_m [1 << BLK_W];
  int lru_m[$];
  int dm_blk [LINES];
  bit dm_v [LINES];
  int e_first, e_cap, e_conf;

  always #5 clk = ~clk;

  miss_classifier #(.BLK_W(BLK_W), .LINES(LINES), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_blk(in_blk), .in_hit(in_hit), .out_valid(out_valid), .out_class(out_class),
    .cnt_compulsory(cnt_compulsory), .cnt_capacity(cnt_capacity), .cnt_conflict(cnt_conflict)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: present one access and queue its expected class.
  task automatic access(input int blk, input bit hit, input logic [1:0] cls, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_blk   = BLK_W'(blk);
    in_hit   = hit;
    exp_q.push_back(cls);
    req_q.push_back(req);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: scoreboard comparison of each produced result.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R1", 1, 0, "result with nothing expected");
      end else begin
        automatic logic [1:0] e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        check(r, int'(out_class), int'(e), "class code");
      end
    end
  end

  task automatic apply_reset();
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R8", int'(out_valid), 0, "out_valid in reset");
    check("R8", int'(cnt_compulsory), 0, "compulsory count in reset");
    check("R8", int'(cnt_capacity), 0, "capacity count in reset");
    check("R8", int'(cnt_conflict), 0, "conflict count in reset");
    rst_n = 1'b1;
    check("R1", int'(in_ready), 1, "in_ready after reset");
    for (int i = 0; i < (1 << BLK_W); i++) seen_m[i] = 1'b0;
    lru_m.delete();
    for (int i = 0; i < LINES; i++) dm_v[i] = 1'b0;
    e_first = 0; e_cap = 0; e_conf = 0;
  endtask

  // Reference model: real direct-mapped cache plus classification rules.
  task automatic model_access(input int blk);
    int idx = blk % LINES;
    bit hit = dm_v[idx] && (dm_blk[idx] == blk);
    int pos = -1;
    logic [1:0] cls;
    string r;
    foreach (lru_m[i]) if (lru_m[i] == blk) pos = i;
    if (hit)            begin cls = 2'b00; r = "R2"; end
    else if (!seen_m[blk]) begin cls = 2'b01; r = "R3"; if (e_first < TOP) e_first++; end
    else if (pos < 0)   begin cls = 2'b10; r = "R4"; if (e_cap < TOP) e_cap++; end
    else                begin cls = 2'b11; r = "R5"; if (e_conf < TOP) e_conf++; end
    seen_m[blk] = 1'b1;
    if (pos >= 0) lru_m.delete(pos);
    lru_m.push_front(blk);
    if (lru_m.size() > LINES) void'(lru_m.pop_back());
    dm_v[idx] = 1'b1;
    dm_blk[idx] = blk;
    access(blk, hit, cls, r);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    apply_reset();

    // Directed: hit refresh decides eviction (R6).
    access(0, 1'b0, 2'b01, "R3");
    access(1, 1'b0, 2'b01, "R3");
    access(2, 1'b0, 2'b01, "R3");
    access(3, 1'b0, 2'b01, "R3");
    access(0, 1'b1, 2'b00, "R2");  // refreshes block 0 in the shadow
    access(5, 1'b0, 2'b01, "R3");  // shadow evicts block 1, not block 0
    access(1, 1'b0, 2'b10, "R6");  // capacity only because of the refresh
    access(5, 1'b0, 2'b11, "R5");  // still in shadow -> conflict
    idle();
    check("R7", int'(cnt_compulsory), 5, "compulsory count");
    check("R7", int'(cnt_capacity), 1, "capacity count");
    check("R7", int'(cnt_conflict), 1, "conflict count");
    idle();
    check("R9", int'(out_valid), 0, "out_valid after idle");
    idle();
    check("R9", int'(cnt_compulsory), 5, "compulsory count after idle");
    check("R9", int'(cnt_conflict), 1, "conflict count after idle");
    check("R2", exp_q.size(), 0, "pending results");

    // Mid-run reset forgets seen blocks.
    apply_reset();
    access(5, 1'b0, 2'b01, "R8");
    access(0, 1'b0, 2'b01, "R8");
    idle();
    check("R8", int'(cnt_compulsory), 2, "compulsory count after reset");
    idle();

    // Random stream against the reference model, saturating counters.
    apply_reset();
    for (int i = 0; i < 500; i++) begin
      model_access($urandom_range(0, 23));
      if (i % 7 == 3) idle();
    end
    idle();
    idle();
    check("R7", int'(cnt_compulsory), e_first, "compulsory count random");
    check("R7", int'(cnt_capacity), e_cap, "capacity count random");
    check("R7", int'(cnt_conflict), e_conf, "conflict count random");
    check("R7", int'(cnt_compulsory), TOP, "compulsory count saturated");
    check("R1", exp_q.size(), 0, "pending results at end");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule